// File: doc/BRIEF.md
# Keyboard Controller Output Port with Reset Pulser

This block holds the eight output lines that a keyboard controller drives towards the rest of the system board, and it carries out the three host commands that act on them. A host-side decoder hands it one command at a time, as a strobe with a command byte and, for a write, a data byte. Code 0xD1 loads a new port value. Code 0xD0 returns the current port value as a read result. Codes 0xF0 to 0xFF drive a chosen subset of the four low port lines low for a fixed number of clocks, after which those lines recover on their own.

The lowest port line is the active-low CPU reset, and the next one gates the A20 address line. Command 0xFE therefore works as a system reset. Lines 5 and 4 are not stored. They mirror the live IRQ12 and IRQ1 request levels. While a pulse is running, the block deasserts its ready output, so a host that presents a further command keeps it held until the pulse is over. The block only acts on the codes listed above. Every other code is accepted and has no effect.

Top module: `kbc_outport`

## Requirements
- R1: After reset, the stored lines 7, 6 and 3..0 all read 1, so port_pins is 0xCF when both IRQ inputs are low. cpu_reset_n and a20_gate read 1, cmd_ready reads 1 and rd_valid reads 0.
- R2: A command is accepted on a clock edge where cmd_valid and cmd_ready are both 1. When code 0xD1 is accepted, port_pins[7:6] and port_pins[3:0] take cmd_data[7:6] and cmd_data[3:0] from the next cycle on. Bits 5 and 4 of cmd_data are ignored.
- R3: port_pins[5] always equals irq12_active and port_pins[4] always equals irq1_active, with no clock delay.
- R4: When code 0xD0 is accepted, rd_valid is 1 for exactly the next cycle. In that cycle rd_data holds the port_pins value from the accepting cycle. rd_valid is 0 at all other times.
- R5: When a code 0xF0..0xFF is accepted, each line i in 0..3 whose code bit i is 0 reads 0 for exactly PULSE_CYCLES cycles, starting the cycle after acceptance. The line then returns to its stored value. Lines whose code bit is 1 do not change.
- R6: Code 0xFF selects no line, so nothing is pulsed and cmd_ready stays 1.
- R7: cmd_ready is 0 for exactly the cycles in which a pulse is active. A command presented during those cycles is not accepted and changes nothing. It takes effect once it is accepted after the pulse.
- R8: cpu_reset_n follows port line 0 and a20_gate follows port line 1. As a result, 0xFE drives cpu_reset_n low for PULSE_CYCLES cycles and leaves a20_gate high.
- R9: Any accepted code other than 0xD0, 0xD1 and 0xF0..0xFF leaves port_pins unchanged and produces no rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe from the host decoder |
| cmd_code | input | 8 | Command byte |
| cmd_data | input | 8 | Data byte used by the port write |
| irq1_active | input | 1 | Live keyboard interrupt request level |
| irq12_active | input | 1 | Live mouse interrupt request level |
| cmd_ready | output | 1 | Block can accept a command this cycle |
| port_pins | output | 8 | Output port lines |
| cpu_reset_n | output | 1 | Active-low CPU reset (port line 0) |
| a20_gate | output | 1 | A20 enable (port line 1) |
| rd_valid | output | 1 | Read result valid for one cycle |
| rd_data | output | 8 | Read result of command 0xD0 |

## Verification
The hardest case to reach is a command that arrives while a pulse is still running. It has to stay held and must not disturb the lines until the pulse ends. The stimulus drives this case directly. It starts a pulse and then raises a port write partway through. It checks that the lines keep their values and that ready stays low, and then that the write lands after the pulse. The random phase mixes writes, reads, pulses with random masks and unrelated codes against a bench model of the port. It also toggles the interrupt levels between commands.

// File: rtl/kbc_outport.sv
module kbc_outport #(
  parameter int unsigned PULSE_CYCLES = 300,
  parameter logic [7:0]  RESET_PORT   = 8'hCF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic [7:0] cmd_data,
  input  logic       irq1_active,
  input  logic       irq12_active,
  output logic       cmd_ready,
  output logic [7:0] port_pins,
  output logic       cpu_reset_n,
  output logic       a20_gate,
  output logic       rd_valid,
  output logic [7:0] rd_data
);
  localparam int unsigned CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

  logic [7:0]    store;
  logic [3:0]    pmask;
  logic [CW-1:0] cnt;

  wire accept  = cmd_valid && cmd_ready;
  wire is_wr   = cmd_code == 8'hD1;
  wire is_rd   = cmd_code == 8'hD0;
  wire is_puls = cmd_code[7:4] == 4'hF;
  wire [3:0] sel = ~cmd_code[3:0];

  assign cmd_ready   = cnt == '0;
  assign port_pins   = {store[7:6], irq12_active, irq1_active, store[3:0] & ~pmask};
  assign cpu_reset_n = port_pins[0];
  assign a20_gate    = port_pins[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store    <= RESET_PORT;
      pmask    <= '0;
      cnt      <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= accept && is_rd;
      if (accept && is_rd) rd_data <= port_pins;
      if (accept && is_wr) store <= {cmd_data[7:6], 2'b00, cmd_data[3:0]};
      if (accept && is_puls && sel != 4'h0) begin
        pmask <= sel;
        cnt   <= LOAD;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) pmask <= '0;
      end
    end
  end
endmodule

module kbc_outport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [7:0] cmd_code,
  input logic [7:0] cmd_data,
  input logic       cmd_ready,
  input logic [7:0] port_pins,
  input logic       cpu_reset_n,
  input logic       rd_valid
);
  wire acc = cmd_valid && cmd_ready;
  wire other = !(cmd_code == 8'hD0 || cmd_code == 8'hD1 || cmd_code[7:4] == 4'hF);

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_code == 8'hD1) |=> (port_pins[7:6] == $past(cmd_data[7:6])));

  assert_read_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc && cmd_code == 8'hD0));

  assert_reset_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_code == 8'hFE) |=> (!cpu_reset_n && !cmd_ready));

  assert_no_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_code == 8'hFF) |=> cmd_ready);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> $stable(port_pins[7:6]));

  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && other) |=> ($stable(port_pins[7:6]) && $stable(port_pins[3:0]) && !rd_valid));
endmodule

bind kbc_outport kbc_outport_chk u_chk (.*);

// File: tb/tb_kbc_outport.sv
module tb_kbc_outport;
  localparam int P = 12;

  logic clk = 0, rst_n = 0, cmd_valid = 0, irq1 = 0, irq12 = 0;
  logic [7:0] cmd_code = 0, cmd_data = 0;
  logic cmd_ready, cpu_reset_n, a20_gate, rd_valid;
  logic [7:0] port_pins, rd_data;
  int total = 0, bad = 0;
  logic [7:0] st;
  bit done = 0;

  kbc_outport #(.PULSE_CYCLES(P)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_data(cmd_data), .irq1_active(irq1), .irq12_active(irq12),
    .cmd_ready(cmd_ready), .port_pins(port_pins), .cpu_reset_n(cpu_reset_n),
    .a20_gate(a20_gate), .rd_valid(rd_valid), .rd_data(rd_data));

  always #10 clk = ~clk;

  function automatic logic [7:0] expp(logic [7:0] s, logic [3:0] m);
    return {s[7:6], irq12, irq1, s[3:0] & ~m};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // drive one command at a negedge; returns after the accepting posedge, at the next negedge
  task automatic issue(logic [7:0] c, logic [7:0] d);
    cmd_code = c; cmd_data = d; cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic pulse_check(logic [7:0] c);
    logic [3:0] m = ~c[3:0];
    issue(c, 8'h00);
    if (m == 0) begin
      chk("R6 ready", {7'd0, cmd_ready}, 8'h01);
      chk("R6 port", port_pins, expp(st, 0));
      return;
    end
    chk("R5 first", port_pins, expp(st, m));
    chk("R7 busy", {7'd0, cmd_ready}, 8'h00);
    chk("R8 rst", {6'd0, a20_gate, cpu_reset_n}, {6'd0, st[1] & ~m[1], st[0] & ~m[0]});
    repeat (P - 1) @(negedge clk);
    chk("R5 last", port_pins, expp(st, m));
    @(negedge clk);
    chk("R5 restore", port_pins, expp(st, 0));
    chk("R7 ready", {7'd0, cmd_ready}, 8'h01);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    st = 8'hCF;
    repeat (3) @(negedge clk);
    chk("R1 port", port_pins, 8'hCF);
    chk("R1 flags", {4'd0, cmd_ready, rd_valid, a20_gate, cpu_reset_n}, 8'h0B);
    rst_n = 1;
    @(negedge clk);

    irq1 = 1; #1;
    chk("R3 irq1", port_pins, expp(st, 0));
    irq12 = 1; irq1 = 0; #1;
    chk("R3 irq12", port_pins, expp(st, 0));

    issue(8'hD1, 8'h35); st = 8'h05;
    chk("R2 write", port_pins, expp(st, 0));
    chk("R8 a20 low", {7'd0, a20_gate}, 8'h00);
    issue(8'hD0, 8'h00);
    chk("R4 valid", {7'd0, rd_valid}, 8'h01);
    chk("R4 data", rd_data, expp(st, 0));
    @(negedge clk);
    chk("R4 one cycle", {7'd0, rd_valid}, 8'h00);

    issue(8'hD1, 8'hFF); st = 8'hCF;
    pulse_check(8'hFE);
    pulse_check(8'hFF);
    pulse_check(8'hF0);

    // R7: write presented mid-pulse is held
    issue(8'hFD, 8'h00);
    @(negedge clk);
    cmd_code = 8'hD1; cmd_data = 8'h00; cmd_valid = 1;
    @(negedge clk);
    chk("R7 held", port_pins, expp(st, 4'h2));
    chk("R7 not ready", {7'd0, cmd_ready}, 8'h00);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0; st = 8'h00;
    chk("R7 applied", port_pins, expp(st, 0));

    issue(8'hAA, 8'h00);
    chk("R9 port", port_pins, expp(st, 0));
    chk("R9 rd", {7'd0, rd_valid}, 8'h00);

    for (int i = 0; i < 300; i++) begin
      int k = $urandom_range(0, 3);
      logic [7:0] d = 8'($urandom);
      irq1 = 1'($urandom); irq12 = 1'($urandom);
      case (k)
        0: begin issue(8'hD1, d); st = {d[7:6], 2'b00, d[3:0]};
                 chk("R2 rand", port_pins, expp(st, 0)); end
        1: begin issue(8'hD0, 8'h00);
                 chk("R4 rand", rd_data, expp(st, 0)); end
        2: pulse_check({4'hF, d[3:0]});
        default: begin
          if (d == 8'hD0 || d == 8'hD1 || d[7:4] == 4'hF) d = 8'h20;
          issue(d, 8'($urandom));
          chk("R9 rand", port_pins, expp(st, 0));
          chk("R9 rand rd", {7'd0, rd_valid}, 8'h00);
        end
      endcase
    end
    finish_run();
  end
endmodule